// File: doc/BRIEF.md
# Flash Interface and Address Mode Controller

This block keeps the protocol state of a serial flash slave interface. It decides whether opcodes arrive one bit per clock on a single data line or one nibble per clock on all four lines, and whether addresses carry three or four bytes. It also holds the top address byte used in three-byte mode, and it runs the two-command software reset with its lockout window. Mode changes come from opcodes that an upstream decoder has already recognised, each marked by a one-cycle command strobe. The quad-enable bit and the power-up address-mode bit come from the configuration store.

Alongside the mode state, the block deserialises opcode bits from the four IO lines at the width that is currently active. It also assembles incoming address bytes into a full 32-bit address. In three-byte mode the stored top byte is put in front of the three received bytes. Every completed four-byte address replaces the stored top byte with its own top byte. A hardware reset input overrides everything and leaves the block in the same state as a software reset, except that no lockout follows it.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After `rst` the block reports one opcode lane and 8 opcode clocks. The address mode equals `boot_4b` (`addr_mode_4b`=`boot_4b`, `addr_bytes` 4 when it is 1 and 3 when it is 0). The stored top byte is 0 and `rst_busy` is 0.
- R2: An accepted command 38h switches to quad opcode mode (`ins_lanes`=4) only when `quad_en`=1, and is ignored when `quad_en`=0. An accepted FFh returns to single-lane mode (`ins_lanes`=1). The change is visible in the cycle after the strobe.
- R3: In single-lane mode, an opcode is built from `io_in[0]` over 8 `shift_en` strobes, most significant bit first. In quad mode it is built from `io_in[3:0]` over 2 strobes, high nibble first with `io_in[3]` as the nibble MSB. `op_vld` pulses for one cycle after the final strobe, and `ins_clocks` reads 8 or 2 to match the mode. `frame_start` restarts the bit count.
- R4: An accepted B7h selects four-byte addressing (`addr_mode_4b`=1, `addr_bytes`=4). An accepted E9h selects three-byte addressing (`addr_mode_4b`=0, `addr_bytes`=3).
- R5: In three-byte mode, after the third byte, `addr_out` = {stored top byte, byte1, byte2, byte3}, with the first byte received in bits 23..16, and `addr_vld` pulses for one cycle. Top-byte bit 0 (address bit 24) selects the upper 16 MB half.
- R6: In four-byte mode, after the fourth byte, `addr_out` = {byte1, byte2, byte3, byte4}, with the first byte received in bits 31..24. The stored top byte becomes byte1.
- R7: An accepted 66h followed directly by an accepted 99h returns the state to the R1 values, with the address mode taken from `boot_4b` at that cycle. `rst_busy` then reads 1 for exactly `RST_CYCLES` cycles, starting in the cycle after the 99h strobe.
- R8: A 99h that does not directly follow an accepted 66h does nothing. Any other accepted command between 66h and 99h cancels the pending reset.
- R9: While `rst_busy`=1, command strobes, address bytes and opcode shift strobes have no effect.
- R10: `hw_rst`=1 takes priority over a command strobed in the same cycle. It forces the R1 state and ends any lockout at once.
- R11: `addr_start` discards any partly received address, and the byte given in the same cycle counts as the first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| hw_rst | input | 1 | Hardware reset request, highest priority |
| cmd_valid | input | 1 | One-cycle command-complete strobe |
| cmd_op | input | 8 | Decoded opcode qualified by cmd_valid |
| quad_en | input | 1 | Quad-enable configuration bit |
| boot_4b | input | 1 | Power-up address mode, 1 selects four bytes |
| addr_start | input | 1 | Start of a new address phase |
| addr_byte_vld | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte, most significant first |
| frame_start | input | 1 | Start of a new opcode phase |
| shift_en | input | 1 | Rising-clock sample strobe for opcode bits |
| io_in | input | 4 | Sampled IO lines |
| ins_lanes | output | 3 | Opcode lane count, 1 or 4 |
| ins_clocks | output | 4 | Clocks per opcode, 8 or 2 |
| addr_bytes | output | 3 | Address byte count, 3 or 4 |
| addr_mode_4b | output | 1 | Current address-mode status bit |
| addr_out | output | 32 | Assembled full address |
| addr_vld | output | 1 | One-cycle pulse when addr_out is new |
| op_byte | output | 8 | Deserialised opcode |
| op_vld | output | 1 | One-cycle pulse when op_byte is new |
| rst_busy | output | 1 | Software reset lockout in progress |

## Verification
A wrong lane mode or address mode appears on `ins_lanes`, `ins_clocks`, `addr_bytes` and `addr_mode_4b` in the cycle after the command that caused it, so those outputs are compared against a reference model after every clock. A corrupt stored top byte stays hidden until the next three-byte address completes, which is why the directed cases follow each top-byte update or reset with a three-byte address. A missed or spurious reset arm shows as a `rst_busy` edge in the cycle after a 99h. An error in the lockout counter only shows when `rst_busy` falls, so the length of the busy run is counted exactly.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
  localparam logic [7:0] OP_QUAD_ON  = 8'h38;
  localparam logic [7:0] OP_QUAD_OFF = 8'hFF;
  localparam logic [7:0] OP_WIDE_ON  = 8'hB7;
  localparam logic [7:0] OP_WIDE_OFF = 8'hE9;
  localparam logic [7:0] OP_RST_ARM  = 8'h66;
  localparam logic [7:0] OP_RST_GO   = 8'h99;

  typedef enum logic {
    BUS_SERIAL = 1'b0,
    BUS_QUAD   = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/fmc_reset_seq.sv
module fmc_reset_seq
  import fmc_pkg::*;
#(
  parameter int RST_CYCLES = 3750
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_rst,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_op,
  output logic       cmd_ok,
  output logic       sw_clear,
  output logic       busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic          armed;
  logic [CW-1:0] cnt;

  assign cmd_ok   = cmd_valid && !busy;
  assign sw_clear = cmd_ok && (cmd_op == OP_RST_GO) && armed;

  always_ff @(posedge clk) begin
    if (rst || hw_rst) begin
      armed <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else begin
      if (cmd_ok) armed <= (cmd_op == OP_RST_ARM);
      if (sw_clear) begin
        busy <= 1'b1;
        cnt  <= CW'(RST_CYCLES - 1);
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  // R7: lockout only begins right after a go command
  a_r7_busy_origin: assert property (@(posedge clk) disable iff (rst || hw_rst)
    $rose(busy) |-> $past(cmd_valid && cmd_op == OP_RST_GO));
  // R7: lockout cannot end while the counter is still running
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (rst || hw_rst)
    (busy && cnt != '0) |=> busy);
  // R9: no command is taken in a lockout cycle
  a_r9_no_cmd_in_lock: assert property (@(posedge clk) disable iff (rst || hw_rst)
    busy |-> !sw_clear);
endmodule

// File: rtl/fmc_mode_regs.sv
module fmc_mode_regs
  import fmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hw_rst,
  input  logic       sw_clear,
  input  logic       cmd_ok,
  input  logic [7:0] cmd_op,
  input  logic       quad_en,
  input  logic       boot_4b,
  output bus_mode_e  bus_mode,
  output logic       four_b
);
  always_ff @(posedge clk) begin
    if (rst || hw_rst || sw_clear) begin
      bus_mode <= BUS_SERIAL;
      four_b   <= boot_4b;
    end else if (cmd_ok) begin
      case (cmd_op)
        OP_QUAD_ON:  if (quad_en) bus_mode <= BUS_QUAD;
        OP_QUAD_OFF: bus_mode <= BUS_SERIAL;
        OP_WIDE_ON:  four_b <= 1'b1;
        OP_WIDE_OFF: four_b <= 1'b0;
        default: ;
      endcase
    end
  end

  // R2: entry to quad opcode mode needs quad enable
  a_r2_quad_gate: assert property (@(posedge clk) disable iff (rst || hw_rst)
    (cmd_ok && cmd_op == OP_QUAD_ON && !quad_en && bus_mode == BUS_SERIAL)
    |=> bus_mode == BUS_SERIAL);
  // R4: wide addressing follows its command
  a_r4_wide_on: assert property (@(posedge clk) disable iff (rst || hw_rst)
    (cmd_ok && cmd_op == OP_WIDE_ON && !sw_clear) |=> four_b);
  // R7: a software reset leaves single-lane mode
  a_r7_serial_after_clear: assert property (@(posedge clk) disable iff (rst || hw_rst)
    sw_clear |=> bus_mode == BUS_SERIAL);
endmodule

// File: rtl/fmc_addr_asm.sv
module fmc_addr_asm #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_rst,
  input  logic              sw_clear,
  input  logic              busy,
  input  logic              four_b,
  input  logic              start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld
);
  localparam int NB    = ADDR_W / BYTE_W;
  localparam int CNT_W = $clog2(NB + 1);
  localparam int ACC_W = ADDR_W - BYTE_W;
  localparam int LOW_W = ADDR_W - 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt, base, nxt, target;
  logic [ACC_W-1:0]  acc, shifted;
  logic [BYTE_W-1:0] ext;
  logic              last;

  always_comb begin
    base    = start ? '0 : cnt;
    nxt     = base + 1'b1;
    target  = four_b ? CNT_W'(NB) : CNT_W'(NB - 1);
    shifted = {acc[LOW_W-1:0], byte_in};
    last    = byte_vld && !busy && (nxt == target);
  end

  always_ff @(posedge clk) begin
    if (rst || hw_rst || sw_clear) begin
      cnt      <= '0;
      acc      <= '0;
      ext      <= '0;
      addr_o   <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= 1'b0;
      if (busy) begin
        cnt <= '0;
      end else if (byte_vld) begin
        acc <= shifted;
        if (last) begin
          cnt      <= '0;
          addr_vld <= 1'b1;
          if (four_b) begin
            addr_o <= {acc, byte_in};
            ext    <= acc[ACC_W-1 -: BYTE_W];
          end else begin
            addr_o <= {ext, acc[LOW_W-1:0], byte_in};
          end
        end else begin
          cnt <= nxt;
        end
      end else if (start) begin
        cnt <= '0;
      end
    end
  end

  // R5: the stored top byte is untouched while in three-byte mode
  a_r5_ext_steady: assert property (@(posedge clk) disable iff (rst || hw_rst)
    (!four_b && !sw_clear) |=> $stable(ext));
  // R6: a wide address leaves its top byte behind
  a_r6_ext_follows: assert property (@(posedge clk) disable iff (rst || hw_rst)
    (addr_vld && $past(four_b)) |-> ext == addr_o[ADDR_W-1 -: BYTE_W]);
  // R9: nothing completes right after a lockout cycle
  a_r9_addr_quiet: assert property (@(posedge clk) disable iff (rst || hw_rst)
    busy |=> !addr_vld);
endmodule

// File: rtl/fmc_op_shift.sv
module fmc_op_shift #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hw_rst,
  input  logic            sw_clear,
  input  logic            busy,
  input  logic            quad,
  input  logic            frame_start,
  input  logic            shift_en,
  input  logic [3:0]      io_in,
  output logic [OP_W-1:0] op_byte,
  output logic            op_vld
);
  localparam int CW = $clog2(OP_W + 1);

  logic [CW-1:0]   cnt, base, nxt;
  logic [OP_W-1:0] sr, shifted;

  always_comb begin
    base    = frame_start ? '0 : cnt;
    nxt     = base + (quad ? CW'(4) : CW'(1));
    shifted = quad ? {sr[OP_W-5:0], io_in} : {sr[OP_W-2:0], io_in[0]};
  end

  always_ff @(posedge clk) begin
    if (rst || hw_rst || sw_clear) begin
      cnt     <= '0;
      sr      <= '0;
      op_byte <= '0;
      op_vld  <= 1'b0;
    end else begin
      op_vld <= 1'b0;
      if (busy) begin
        cnt <= '0;
      end else if (shift_en) begin
        sr <= shifted;
        if (nxt == CW'(OP_W)) begin
          cnt     <= '0;
          op_vld  <= 1'b1;
          op_byte <= shifted;
        end else begin
          cnt <= nxt;
        end
      end else if (frame_start) begin
        cnt <= '0;
      end
    end
  end

  // R3: the bit count never reaches a full opcode without wrapping
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst || hw_rst)
    cnt < CW'(OP_W));
  // R9: no opcode completes right after a lockout cycle
  a_r9_op_quiet: assert property (@(posedge clk) disable iff (rst || hw_rst)
    busy |=> !op_vld);
endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int RST_CYCLES = 3750,
  parameter int ADDR_W     = 32,
  parameter int OP_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_rst,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic              quad_en,
  input  logic              boot_4b,
  input  logic              addr_start,
  input  logic              addr_byte_vld,
  input  logic [7:0]        addr_byte,
  input  logic              frame_start,
  input  logic              shift_en,
  input  logic [3:0]        io_in,
  output logic [2:0]        ins_lanes,
  output logic [3:0]        ins_clocks,
  output logic [2:0]        addr_bytes,
  output logic              addr_mode_4b,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_vld,
  output logic [OP_W-1:0]   op_byte,
  output logic              op_vld,
  output logic              rst_busy
);
  logic      cmd_ok, sw_clear, busy, four_b;
  bus_mode_e bus_mode;

  fmc_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .hw_rst(hw_rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ok(cmd_ok), .sw_clear(sw_clear), .busy(busy)
  );

  fmc_mode_regs u_mode (
    .clk(clk), .rst(rst), .hw_rst(hw_rst), .sw_clear(sw_clear), .cmd_ok(cmd_ok),
    .cmd_op(cmd_op), .quad_en(quad_en), .boot_4b(boot_4b),
    .bus_mode(bus_mode), .four_b(four_b)
  );

  fmc_addr_asm #(.ADDR_W(ADDR_W), .BYTE_W(8)) u_addr (
    .clk(clk), .rst(rst), .hw_rst(hw_rst), .sw_clear(sw_clear), .busy(busy),
    .four_b(four_b), .start(addr_start), .byte_vld(addr_byte_vld), .byte_in(addr_byte),
    .addr_o(addr_out), .addr_vld(addr_vld)
  );

  fmc_op_shift #(.OP_W(OP_W)) u_op (
    .clk(clk), .rst(rst), .hw_rst(hw_rst), .sw_clear(sw_clear), .busy(busy),
    .quad(bus_mode == BUS_QUAD), .frame_start(frame_start), .shift_en(shift_en),
    .io_in(io_in), .op_byte(op_byte), .op_vld(op_vld)
  );

  assign ins_lanes    = (bus_mode == BUS_QUAD) ? 3'd4 : 3'd1;
  assign ins_clocks   = (bus_mode == BUS_QUAD) ? 4'd2 : 4'd8;
  assign addr_bytes   = four_b ? 3'd4 : 3'd3;
  assign addr_mode_4b = four_b;
  assign rst_busy     = busy;

  // R10: a hardware reset ends any lockout on the next edge
  a_r10_hw_clears_lock: assert property (@(posedge clk) disable iff (rst)
    hw_rst |=> !rst_busy && ins_lanes == 3'd1);
endmodule

// File: tb/flash_mode_ctrl_tb.sv
module flash_mode_ctrl_tb;
  localparam int RST_N = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, hw_rst = 1'b0, cmd_valid = 1'b0, quad_en = 1'b0, boot_4b = 1'b0;
  logic addr_start = 1'b0, addr_byte_vld = 1'b0, frame_start = 1'b0, shift_en = 1'b0;
  logic [7:0] cmd_op = 8'h00, addr_byte = 8'h00;
  logic [3:0] io_in = 4'h0;
  logic [2:0] ins_lanes, addr_bytes;
  logic [3:0] ins_clocks;
  logic addr_mode_4b, addr_vld, op_vld, rst_busy;
  logic [31:0] addr_out;
  logic [7:0] op_byte;

  flash_mode_ctrl #(.RST_CYCLES(RST_N)) u_dut (
    .clk(clk), .rst(rst), .hw_rst(hw_rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .quad_en(quad_en), .boot_4b(boot_4b), .addr_start(addr_start),
    .addr_byte_vld(addr_byte_vld), .addr_byte(addr_byte), .frame_start(frame_start),
    .shift_en(shift_en), .io_in(io_in), .ins_lanes(ins_lanes), .ins_clocks(ins_clocks),
    .addr_bytes(addr_bytes), .addr_mode_4b(addr_mode_4b), .addr_out(addr_out),
    .addr_vld(addr_vld), .op_byte(op_byte), .op_vld(op_vld), .rst_busy(rst_busy)
  );

  int n_chk = 0, n_bad = 0, busy_run = 0;
  bit m_quad = 0, m_wide = 0, m_armed = 0;
  int m_busy = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_lanes(bit q);
    return q ? 3'd4 : 3'd1;
  endfunction

  // one clock: update the reference model, compare mode outputs, drop strobes
  task automatic tick();
    bit acc = cmd_valid && (m_busy == 0);
    @(posedge clk);
    if (rst || hw_rst) begin
      m_quad = 0; m_wide = boot_4b; m_armed = 0; m_busy = 0;
    end else begin
      if (m_busy > 0) m_busy--;
      if (acc) begin
        if (cmd_op == 8'h99 && m_armed) begin
          m_quad = 0; m_wide = boot_4b; m_busy = RST_N;
        end else begin
          case (cmd_op)
            8'h38: if (quad_en) m_quad = 1;
            8'hFF: m_quad = 0;
            8'hB7: m_wide = 1;
            8'hE9: m_wide = 0;
            default: ;
          endcase
        end
        m_armed = (cmd_op == 8'h66);
      end
    end
    #2;
    chk("R2 lanes", {29'd0, ins_lanes}, {29'd0, exp_lanes(m_quad)});
    chk("R3 clocks", {28'd0, ins_clocks}, m_quad ? 32'd2 : 32'd8);
    chk("R4 mode", {31'd0, addr_mode_4b}, {31'd0, m_wide});
    chk("R4 bytes", {29'd0, addr_bytes}, m_wide ? 32'd4 : 32'd3);
    chk("R7 busy", {31'd0, rst_busy}, {31'd0, m_busy > 0});
    if (rst_busy) busy_run++;
    @(negedge clk);
    cmd_valid = 0; addr_start = 0; addr_byte_vld = 0;
    frame_start = 0; shift_en = 0; hw_rst = 0;
  endtask

  task automatic do_cmd(logic [7:0] op);
    cmd_valid = 1; cmd_op = op; tick();
  endtask

  task automatic send_byte(logic [7:0] b, bit first);
    addr_start = first; addr_byte_vld = 1; addr_byte = b; tick();
  endtask

  task automatic shift(logic [3:0] io, bit first);
    frame_start = first; shift_en = 1; io_in = io; tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] ops [8] = '{8'h38, 8'hFF, 8'hB7, 8'hE9, 8'h66, 8'h99, 8'h03, 8'h66};
    void'($urandom(32'h51A7));
    @(negedge clk);
    tick(); tick();
    rst = 0;
    tick();
    // R1: reset state
    chk("R1 lanes", {29'd0, ins_lanes}, 32'd1);
    chk("R1 busy", {31'd0, rst_busy}, 32'd0);
    chk("R1 vld", {31'd0, addr_vld}, 32'd0);

    // R2: quad entry gated by quad_en
    do_cmd(8'h38);
    chk("R2 gated", {29'd0, ins_lanes}, 32'd1);
    quad_en = 1;
    do_cmd(8'h38);
    chk("R2 enter", {29'd0, ins_lanes}, 32'd4);
    do_cmd(8'hFF);
    chk("R2 exit", {29'd0, ins_lanes}, 32'd1);

    // R3: serial opcode MSB first on io_in[0]
    for (int i = 7; i >= 0; i--) begin
      shift({3'b000, 8'hA5 >> i}, i == 7);
      if (i == 1) chk("R3 early", {31'd0, op_vld}, 32'd0);
    end
    chk("R3 serial vld", {31'd0, op_vld}, 32'd1);
    chk("R3 serial byte", {24'd0, op_byte}, 32'hA5);
    do_cmd(8'h38);
    shift(4'h3, 1'b1);
    chk("R3 half", {31'd0, op_vld}, 32'd0);
    shift(4'hC, 1'b0);
    chk("R3 quad byte", {24'd0, op_byte}, 32'h3C);
    chk("R3 quad vld", {31'd0, op_vld}, 32'd1);
    do_cmd(8'hFF);

    // R4, R6: four-byte address rewrites stored top byte
    do_cmd(8'hB7);
    send_byte(8'h01, 1); send_byte(8'h34, 0); send_byte(8'h56, 0);
    chk("R6 not yet", {31'd0, addr_vld}, 32'd0);
    send_byte(8'h78, 0);
    chk("R6 vld", {31'd0, addr_vld}, 32'd1);
    chk("R6 addr", addr_out, 32'h01345678);
    // R5: three-byte address uses stored top byte, upper half
    do_cmd(8'hE9);
    send_byte(8'hAB, 1); send_byte(8'hCD, 0); send_byte(8'hEF, 0);
    chk("R5 vld", {31'd0, addr_vld}, 32'd1);
    chk("R5 addr", addr_out, 32'h01ABCDEF);
    chk("R5 upper half", {31'd0, addr_out[24]}, 32'd1);
    // R11: restart discards partial address
    send_byte(8'h11, 1); send_byte(8'h22, 0);
    send_byte(8'h33, 1); send_byte(8'h44, 0); send_byte(8'h55, 0);
    chk("R11 addr", addr_out, 32'h01334455);
    chk("R11 vld", {31'd0, addr_vld}, 32'd1);

    // R8: interrupted or lone reset does nothing
    do_cmd(8'h38);
    do_cmd(8'h66); do_cmd(8'h03); do_cmd(8'h99);
    chk("R8 cancel busy", {31'd0, rst_busy}, 32'd0);
    chk("R8 cancel lanes", {29'd0, ins_lanes}, 32'd4);
    do_cmd(8'h99);
    chk("R8 lone", {31'd0, rst_busy}, 32'd0);

    // R7: valid reset sequence, R9 lockout
    boot_4b = 1;
    busy_run = 0;
    do_cmd(8'h66); do_cmd(8'h99);
    chk("R7 busy", {31'd0, rst_busy}, 32'd1);
    chk("R7 lanes", {29'd0, ins_lanes}, 32'd1);
    chk("R7 mode", {31'd0, addr_mode_4b}, 32'd1);
    do_cmd(8'h38);
    chk("R9 cmd ignored", {29'd0, ins_lanes}, 32'd1);
    send_byte(8'h01, 1); send_byte(8'h02, 0); send_byte(8'h03, 0); send_byte(8'h04, 0);
    chk("R9 addr ignored", {31'd0, addr_vld}, 32'd0);
    shift(4'h1, 1'b1); shift(4'h2, 1'b0);
    for (int i = 0; i < 8; i++) shift(4'h1, i == 0);
    chk("R9 op ignored", {31'd0, op_vld}, 32'd0);
    while (rst_busy) tick();
    chk("R7 length", busy_run, RST_N);
    do_cmd(8'hE9);
    send_byte(8'h00, 1); send_byte(8'h00, 0); send_byte(8'h01, 0);
    chk("R7 top byte cleared", addr_out, 32'h00000001);

    // R10: hardware reset beats command, ends lockout, clears top byte
    do_cmd(8'hB7);
    send_byte(8'hFE, 1); send_byte(8'h00, 0); send_byte(8'h00, 0); send_byte(8'h00, 0);
    do_cmd(8'h38);
    hw_rst = 1; cmd_valid = 1; cmd_op = 8'hFF; tick();
    chk("R10 lanes", {29'd0, ins_lanes}, 32'd1);
    do_cmd(8'h38);
    hw_rst = 1; cmd_valid = 1; cmd_op = 8'h38; tick();
    chk("R10 priority", {29'd0, ins_lanes}, 32'd1);
    do_cmd(8'h66); do_cmd(8'h99); tick(); tick();
    hw_rst = 1; tick();
    chk("R10 lock ended", {31'd0, rst_busy}, 32'd0);
    chk("R10 mode", {31'd0, addr_mode_4b}, 32'd1);
    do_cmd(8'hE9);
    send_byte(8'h12, 1); send_byte(8'h34, 0); send_byte(8'h56, 0);
    chk("R10 top byte", addr_out, 32'h00123456);

    // random commands mixed with resets, checked every cycle by the model
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r = $urandom;
      cmd_valid = r[0] | r[1];
      cmd_op    = ops[r[4:2]];
      quad_en   = r[5];
      boot_4b   = r[6];
      hw_rst    = (r[15:8] == 8'd0);
      tick();
    end

    summary();
    $finish;
  end
endmodule